// File: doc/BRIEF.md
# Four-Way Set-Associative Cache with Tree Pseudo-LRU

This block is a unified, four-way set-associative cache for 32-bit word accesses. A processor request carries a valid strobe, an address, a read/write flag and write data. The block answers with a one-cycle done pulse, a hit flag and read data. The default geometry is 128 sets of four lines with four words per line, which gives 8 KBytes of data storage. Each line has one valid bit, and each set has three replacement bits that form a binary tree.

A read that misses fetches the whole 16-byte line from memory as a four-beat burst. The line goes into a free way or into the way that the tree picks, and the requested word is then returned. Writes always go through to memory. A write that hits also updates the cached word. A write that misses does not allocate a line.

Top module: `assoc4_cache`

## Requirements
- R1: After reset, `cpu_ready_o` is 1, `cpu_done_o`, `mem_rd_req_o` and `mem_wr_en_o` are 0, and no line is valid, so the first read of any address misses.
- R2: An address splits into a byte offset in bits 3:0, a set index in bits 10:4 and a tag in bits 31:11, and bits 3:2 select the word within the line. Four lines with different tags in one set are all held at the same time.
- R3: A read miss holds `mem_rd_req_o` high with a stable, line-aligned `mem_rd_addr_o`. It takes exactly four beats, each marked by `mem_rd_valid_i`, in order of rising word address, and gaps between beats are allowed. The cycle after the last beat gives `cpu_done_o`=1 and `cpu_hit_o`=0, with the requested word on `cpu_rdata_o`.
- R4: A read hit gives `cpu_done_o`=1 and `cpu_hit_o`=1 with the cached word in the first cycle after the request is accepted, and it makes no memory read request.
- R5: A miss fills the lowest-numbered invalid way of the set. The replacement tree is used only when all four ways are valid.
- R6: Every hit and every fill points the tree at the accessed line. B0 is set to 1 for line 0 or 1 and to 0 for line 2 or 3. The bit of the accessed pair records that pair's newest line: for the L0/L1 pair, 1 means L0, and for the L2/L3 pair, 1 means L2. The bit of the other pair is left unchanged.
- R7: In a full set, the victim is taken from the pair that B0 marks as less recent, and it is the older line of that pair. After the usage order L0, L2, L3, L1, the victim is L2.
- R8: A write hit updates the cached word and reports `cpu_hit_o`=1. In the same cycle it raises `mem_wr_en_o` with the address and data of the request.
- R9: A write miss reports `cpu_hit_o`=0, forwards the write to memory and allocates no line, so a later read of that address still misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req_i | input | 1 | Request strobe, taken when `cpu_ready_o` is 1 |
| cpu_addr_i | input | 32 | Byte address of the word |
| cpu_we_i | input | 1 | 1 = write, 0 = read |
| cpu_wdata_i | input | 32 | Write data |
| cpu_ready_o | output | 1 | Block is idle and accepts a request |
| cpu_done_o | output | 1 | One-cycle completion pulse |
| cpu_hit_o | output | 1 | Request hit in the cache (valid with done) |
| cpu_rdata_o | output | 32 | Read data (valid with done on reads) |
| mem_rd_req_o | output | 1 | Line burst read request |
| mem_rd_addr_o | output | 32 | Line-aligned burst address |
| mem_rd_valid_i | input | 1 | Burst beat strobe |
| mem_rd_data_i | input | 32 | Burst beat data |
| mem_wr_en_o | output | 1 | Write-through strobe |
| mem_wr_addr_o | output | 32 | Write-through address |
| mem_wr_data_o | output | 32 | Write-through data |

## Verification
The bench drives a full set through the usage order L0, L2, L3, L1 and then probes which tag was lost. If a design kept true LRU order, or updated the other pair's bit, it would evict L0 or L3 instead of L2. A second sequence touches only one pair after the fills, so it exposes a design that clears the untouched pair's bit. Fill bursts arrive with gaps between beats. A design that counts cycles instead of strobes, or that writes the beats in the wrong order, returns the wrong word. A write miss followed by a read of the same address catches a design that allocates on write, since that read would then hit.

// File: rtl/assoc4_cache_pkg.sv
package assoc4_cache_pkg;
   localparam int unsigned N_WAYS = 4;
   localparam int unsigned WAY_W  = 2;
   typedef logic [WAY_W-1:0] way_idx_t;
   typedef enum logic [1:0] {ST_IDLE, ST_LOOK, ST_FILL, ST_RESP} cstate_e;
endpackage

// File: rtl/assoc4_plru.sv
module assoc4_plru
   import assoc4_cache_pkg::*;
#(
   parameter int unsigned SETS  = 128,
   parameter int unsigned IDX_W = $clog2(SETS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] rd_set_i,
   input  logic             upd_en_i,
   input  logic [IDX_W-1:0] upd_set_i,
   input  way_idx_t         upd_way_i,
   output way_idx_t         victim_o
);
   // bit0 = pair flag (1: L0/L1 newer), bit1 = L0 newer in low pair, bit2 = L2 newer in high pair
   logic [2:0] tree_q [SETS];
   logic [2:0] cur;

   if (2**IDX_W != SETS) begin : g_bad_sets
      $error("SETS must be a power of two");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < SETS; s++) tree_q[s] <= '0;
      end else if (upd_en_i) begin
         tree_q[upd_set_i][0] <= ~upd_way_i[1];
         if (!upd_way_i[1]) tree_q[upd_set_i][1] <= ~upd_way_i[0];
         else               tree_q[upd_set_i][2] <= ~upd_way_i[0];
      end
   end

   always_comb begin
      cur = tree_q[rd_set_i];
      if (cur[0]) victim_o = cur[2] ? way_idx_t'(3) : way_idx_t'(2);
      else        victim_o = cur[1] ? way_idx_t'(1) : way_idx_t'(0);
   end

   AST_NEWEST_NOT_VICTIM: assert property (@(posedge clk) disable iff (!rst_n)
      upd_en_i && (upd_set_i == rd_set_i) |=>
         (victim_o != $past(upd_way_i)) || (rd_set_i != $past(rd_set_i))); // R6
endmodule

// File: rtl/assoc4_match.sv
module assoc4_match
   import assoc4_cache_pkg::*;
#(
   parameter int unsigned TAG_W = 21
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [N_WAYS-1:0][TAG_W-1:0]  tags_i,
   input  logic [N_WAYS-1:0]             valid_i,
   input  logic [TAG_W-1:0]              tag_i,
   output logic                          hit_o,
   output way_idx_t                      hit_way_o,
   output logic                          free_o,
   output way_idx_t                      free_way_o
);
   logic [N_WAYS-1:0] hit_vec;

   for (genvar w = 0; w < N_WAYS; w++) begin : g_cmp
      assign hit_vec[w] = valid_i[w] && (tags_i[w] == tag_i);
   end

   assign hit_o  = |hit_vec;
   assign free_o = ~&valid_i;

   always_comb begin
      hit_way_o  = '0;
      free_way_o = '0;
      for (int w = N_WAYS - 1; w >= 0; w--) begin
         if (hit_vec[w])  hit_way_o  = way_idx_t'(w);
         if (!valid_i[w]) free_way_o = way_idx_t'(w);
      end
   end

   AST_SINGLE_WAY_HIT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(hit_vec)); // R2
endmodule

// File: rtl/assoc4_cache.sv
module assoc4_cache
   import assoc4_cache_pkg::*;
#(
   parameter int unsigned ADDR_W     = 32,
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned SETS       = 128,
   parameter int unsigned LINE_WORDS = 4,
   parameter int unsigned BSEL_W     = $clog2(DATA_W / 8),
   parameter int unsigned WSEL_W     = $clog2(LINE_WORDS),
   parameter int unsigned OFF_W      = BSEL_W + WSEL_W,
   parameter int unsigned IDX_W      = $clog2(SETS),
   parameter int unsigned TAG_W      = ADDR_W - IDX_W - OFF_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_req_i,
   input  logic [ADDR_W-1:0] cpu_addr_i,
   input  logic              cpu_we_i,
   input  logic [DATA_W-1:0] cpu_wdata_i,
   output logic              cpu_ready_o,
   output logic              cpu_done_o,
   output logic              cpu_hit_o,
   output logic [DATA_W-1:0] cpu_rdata_o,
   output logic              mem_rd_req_o,
   output logic [ADDR_W-1:0] mem_rd_addr_o,
   input  logic              mem_rd_valid_i,
   input  logic [DATA_W-1:0] mem_rd_data_i,
   output logic              mem_wr_en_o,
   output logic [ADDR_W-1:0] mem_wr_addr_o,
   output logic [DATA_W-1:0] mem_wr_data_o
);
   if (DATA_W % 8 != 0 || 2**WSEL_W != LINE_WORDS || LINE_WORDS < 2) begin : g_bad_geom
      $error("DATA_W must be whole bytes and LINE_WORDS a power of two of at least 2");
   end
   if (TAG_W < 1) begin : g_bad_tag
      $error("address too narrow for the chosen geometry");
   end

   cstate_e               state_q;
   logic [ADDR_W-1:0]     addr_q;
   logic                  we_q;
   logic [DATA_W-1:0]     wdata_q;
   way_idx_t              vict_q;
   logic [WSEL_W-1:0]     beat_q;
   logic [N_WAYS-1:0]     valid_q [SETS];

   logic [IDX_W-1:0]      set_idx;
   logic [TAG_W-1:0]      tag;
   logic [WSEL_W-1:0]     wsel;
   logic [N_WAYS-1:0][TAG_W-1:0]  rd_tags;
   logic [N_WAYS-1:0][DATA_W-1:0] rd_words;
   logic                  hit, free;
   way_idx_t              hit_way, free_way, tree_way, victim, upd_way;
   logic                  look, rd_hit, wr_hit, rd_miss, fill_beat, fill_last, upd_en;

   assign set_idx   = addr_q[OFF_W +: IDX_W];
   assign tag       = addr_q[ADDR_W-1 -: TAG_W];
   assign wsel      = addr_q[BSEL_W +: WSEL_W];
   assign look      = (state_q == ST_LOOK);
   assign rd_hit    = look && !we_q && hit;
   assign wr_hit    = look &&  we_q && hit;
   assign rd_miss   = look && !we_q && !hit;
   assign fill_beat = (state_q == ST_FILL) && mem_rd_valid_i;
   assign fill_last = fill_beat && (beat_q == WSEL_W'(LINE_WORDS - 1));
   assign victim    = free ? free_way : tree_way;
   assign upd_en    = rd_hit || wr_hit || fill_last;
   assign upd_way   = (state_q == ST_FILL) ? vict_q : hit_way;

   for (genvar w = 0; w < N_WAYS; w++) begin : g_way
      logic [TAG_W-1:0]  tag_mem  [SETS];
      logic [DATA_W-1:0] data_mem [SETS][LINE_WORDS];
      always_ff @(posedge clk) begin
         if (fill_beat && vict_q == way_idx_t'(w)) data_mem[set_idx][beat_q] <= mem_rd_data_i;
         if (wr_hit && hit_way == way_idx_t'(w))   data_mem[set_idx][wsel]   <= wdata_q;
         if (fill_last && vict_q == way_idx_t'(w)) tag_mem[set_idx]          <= tag;
      end
      assign rd_tags[w]  = tag_mem[set_idx];
      assign rd_words[w] = data_mem[set_idx][wsel];
   end

   assoc4_match #(.TAG_W(TAG_W)) u_match (
      .clk(clk), .rst_n(rst_n), .tags_i(rd_tags), .valid_i(valid_q[set_idx]), .tag_i(tag),
      .hit_o(hit), .hit_way_o(hit_way), .free_o(free), .free_way_o(free_way));

   assoc4_plru #(.SETS(SETS), .IDX_W(IDX_W)) u_plru (
      .clk(clk), .rst_n(rst_n), .rd_set_i(set_idx), .upd_en_i(upd_en),
      .upd_set_i(set_idx), .upd_way_i(upd_way), .victim_o(tree_way));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         addr_q  <= '0;
         we_q    <= 1'b0;
         wdata_q <= '0;
         vict_q  <= '0;
         beat_q  <= '0;
         for (int s = 0; s < SETS; s++) valid_q[s] <= '0;
      end else begin
         unique case (state_q)
            ST_IDLE: if (cpu_req_i) begin
               addr_q  <= cpu_addr_i;
               we_q    <= cpu_we_i;
               wdata_q <= cpu_wdata_i;
               state_q <= ST_LOOK;
            end
            ST_LOOK: if (rd_miss) begin
               vict_q  <= victim;
               beat_q  <= '0;
               state_q <= ST_FILL;
            end else begin
               state_q <= ST_IDLE;
            end
            ST_FILL: if (fill_beat) begin
               beat_q <= beat_q + 1'b1;
               if (fill_last) begin
                  valid_q[set_idx][vict_q] <= 1'b1;
                  state_q <= ST_RESP;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign cpu_ready_o   = (state_q == ST_IDLE);
   assign cpu_done_o    = (look && !rd_miss) || (state_q == ST_RESP);
   assign cpu_hit_o     = look && hit;
   assign cpu_rdata_o   = look ? rd_words[hit_way] : rd_words[vict_q];
   assign mem_rd_req_o  = (state_q == ST_FILL);
   assign mem_rd_addr_o = {addr_q[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
   assign mem_wr_en_o   = look && we_q;
   assign mem_wr_addr_o = addr_q;
   assign mem_wr_data_o = wdata_q;

   AST_FILL_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_req_o |=> !mem_rd_req_o || $stable(mem_rd_addr_o)); // R3
   AST_FILL_ENDS_IN_MISS_RESP: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(mem_rd_req_o) |-> cpu_done_o && !cpu_hit_o); // R3
   AST_HIT_NO_FILL: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_done_o && cpu_hit_o |=> !mem_rd_req_o); // R4
   AST_WRITE_THROUGH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr_en_o |-> cpu_done_o); // R8
   AST_WRITE_NO_ALLOC: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr_en_o |=> !mem_rd_req_o); // R9
endmodule

// File: tb/assoc4_cache_tb_top.sv
`timescale 1ns/1ps
module assoc4_cache_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cpu_req_i = 1'b0, cpu_we_i = 1'b0;
   logic [31:0] cpu_addr_i = '0, cpu_wdata_i = '0;
   logic        cpu_ready_o, cpu_done_o, cpu_hit_o;
   logic [31:0] cpu_rdata_o;
   logic        mem_rd_req_o, mem_wr_en_o;
   logic [31:0] mem_rd_addr_o, mem_wr_addr_o, mem_wr_data_o;
   logic        mem_rd_valid_i = 1'b0;
   logic [31:0] mem_rd_data_i = '0;

   int errors = 0;
   int checks = 0;

   always #2 clk = ~clk;

   assoc4_cache dut_i (
      .clk(clk), .rst_n(rst_n), .cpu_req_i(cpu_req_i), .cpu_addr_i(cpu_addr_i),
      .cpu_we_i(cpu_we_i), .cpu_wdata_i(cpu_wdata_i), .cpu_ready_o(cpu_ready_o),
      .cpu_done_o(cpu_done_o), .cpu_hit_o(cpu_hit_o), .cpu_rdata_o(cpu_rdata_o),
      .mem_rd_req_o(mem_rd_req_o), .mem_rd_addr_o(mem_rd_addr_o),
      .mem_rd_valid_i(mem_rd_valid_i), .mem_rd_data_i(mem_rd_data_i),
      .mem_wr_en_o(mem_wr_en_o), .mem_wr_addr_o(mem_wr_addr_o), .mem_wr_data_o(mem_wr_data_o));

   // memory model
   logic [31:0] mem_ovr [logic [31:0]];
   int          beat = 0;
   int          beats_given = 0;
   bit          fill_seen = 0;
   logic [31:0] fill_addr = '0;

   function automatic logic [31:0] mem_read(input logic [31:0] a);
      if (mem_ovr.exists(a)) return mem_ovr[a];
      return (a ^ 32'hC3A5_0000) + 32'h0000_0011;
   endfunction

   function automatic logic [31:0] mk(input int tg, input int st, input int wd);
      return {21'(tg), 7'(st), 2'(wd), 2'b00};
   endfunction

   always @(negedge clk) begin
      if (mem_wr_en_o) mem_ovr[mem_wr_addr_o] = mem_wr_data_o;
      if (mem_rd_req_o) begin
         if (!fill_seen) fill_addr = mem_rd_addr_o;
         fill_seen = 1;
         if (!mem_rd_valid_i && beat < 4) begin
            mem_rd_valid_i = 1'b1;
            mem_rd_data_i  = mem_read(mem_rd_addr_o + 32'(4 * beat));
            beat++;
            beats_given++;
         end else begin
            mem_rd_valid_i = 1'b0;
         end
      end else begin
         mem_rd_valid_i = 1'b0;
         beat = 0;
      end
   end

   task automatic check(input bit ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   // one processor access; results captured in the done cycle
   logic        r_hit, r_wr;
   logic [31:0] r_data, r_wa, r_wd;
   int          r_wait;

   task automatic cpu_op(input bit we, input logic [31:0] a, input logic [31:0] d);
      int n = 0;
      fill_seen = 0;
      beats_given = 0;
      @(negedge clk);
      cpu_req_i = 1'b1; cpu_we_i = we; cpu_addr_i = a; cpu_wdata_i = d;
      @(negedge clk);
      cpu_req_i = 1'b0;
      while (!cpu_done_o && n < 200) begin
         @(negedge clk);
         n++;
      end
      r_wait = n;
      r_hit  = cpu_hit_o;
      r_data = cpu_rdata_o;
      r_wr   = mem_wr_en_o;
      r_wa   = mem_wr_addr_o;
      r_wd   = mem_wr_data_o;
      check(n < 200, "R3", "response timeout", 32'(n), 32'd200);
   endtask

   task automatic expect_read(input logic [31:0] a, input bit exp_hit, input string req);
      cpu_op(1'b0, a, '0);
      check(r_hit == exp_hit, req, "hit flag", 32'(r_hit), 32'(exp_hit));
      check(r_data == mem_read(a), req, "read data", r_data, mem_read(a));
   endtask

   task automatic t_reset();
      check(cpu_ready_o === 1'b1, "R1", "ready after reset", 32'(cpu_ready_o), 32'd1);
      check(cpu_done_o === 1'b0 && mem_rd_req_o === 1'b0 && mem_wr_en_o === 1'b0,
            "R1", "idle outputs", {cpu_done_o, mem_rd_req_o, mem_wr_en_o}, 32'd0);
   endtask

   task automatic t_miss_then_hit();
      logic [31:0] a = mk(21'h1ABCD, 5, 2);
      expect_read(a, 1'b0, "R1");
      check(fill_seen && fill_addr == (a & ~32'hF), "R3", "burst line address", fill_addr, a & ~32'hF);
      check(beats_given == 4, "R3", "beat count", 32'(beats_given), 32'd4);
      expect_read(a, 1'b1, "R4");
      check(r_wait == 0 && !fill_seen, "R4", "hit latency/no fill", 32'(r_wait), 32'd0);
      expect_read(mk(21'h1ABCD, 5, 0), 1'b1, "R2");
      expect_read(mk(21'h1ABCD, 5, 3), 1'b1, "R2");
   endtask

   task automatic fill_set(input int st, input int base);
      for (int t = 0; t < 4; t++) expect_read(mk(base + t, st, 1), 1'b0, "R5");
   endtask

   task automatic t_fill_and_tree_default();
      fill_set(9, 16);
      for (int t = 0; t < 4; t++) expect_read(mk(16 + t, 9, 1), 1'b1, "R5");
      expect_read(mk(40, 9, 1), 1'b0, "R7");
      expect_read(mk(17, 9, 1), 1'b1, "R7");
      expect_read(mk(18, 9, 1), 1'b1, "R7");
      expect_read(mk(19, 9, 1), 1'b1, "R7");
      expect_read(mk(16, 9, 1), 1'b0, "R7");   // L0 was the victim
   endtask

   task automatic t_order_l0_l2_l3_l1();
      fill_set(20, 64);
      expect_read(mk(64, 20, 0), 1'b1, "R6");
      expect_read(mk(66, 20, 0), 1'b1, "R6");
      expect_read(mk(67, 20, 0), 1'b1, "R6");
      expect_read(mk(65, 20, 0), 1'b1, "R6");
      expect_read(mk(99, 20, 0), 1'b0, "R7");
      expect_read(mk(64, 20, 0), 1'b1, "R7");
      expect_read(mk(65, 20, 0), 1'b1, "R7");
      expect_read(mk(67, 20, 0), 1'b1, "R7");
      expect_read(mk(66, 20, 0), 1'b0, "R7");  // L2 was the victim, not L0
   endtask

   task automatic t_other_pair_kept();
      fill_set(30, 128);
      expect_read(mk(130, 30, 3), 1'b1, "R6");
      expect_read(mk(128, 30, 3), 1'b1, "R6");
      expect_read(mk(129, 30, 3), 1'b1, "R6");
      expect_read(mk(200, 30, 3), 1'b0, "R6");
      expect_read(mk(130, 30, 3), 1'b1, "R6");
      expect_read(mk(128, 30, 3), 1'b1, "R6");
      expect_read(mk(129, 30, 3), 1'b1, "R6");
      expect_read(mk(131, 30, 3), 1'b0, "R6");  // L3 was the victim
   endtask

   task automatic t_write_hit();
      logic [31:0] a = mk(21'h1ABCD, 5, 2);
      cpu_op(1'b1, a, 32'hDEAD_0001);
      check(r_hit == 1'b1, "R8", "write hit flag", 32'(r_hit), 32'd1);
      check(r_wr && r_wa == a && r_wd == 32'hDEAD_0001, "R8", "write-through", r_wd, 32'hDEAD_0001);
      cpu_op(1'b0, a, '0);
      check(r_hit && r_data == 32'hDEAD_0001, "R8", "updated word", r_data, 32'hDEAD_0001);
   endtask

   task automatic t_write_miss();
      logic [31:0] a = mk(21'h0F00F, 40, 1);
      cpu_op(1'b1, a, 32'hBEEF_0002);
      check(r_hit == 1'b0 && !fill_seen, "R9", "write miss no fill", 32'(r_hit), 32'd0);
      check(r_wr && r_wa == a && r_wd == 32'hBEEF_0002, "R9", "write forwarded", r_wd, 32'hBEEF_0002);
      cpu_op(1'b0, a, '0);
      check(r_hit == 1'b0, "R9", "no allocation", 32'(r_hit), 32'd0);
      check(r_data == 32'hBEEF_0002, "R9", "data from memory", r_data, 32'hBEEF_0002);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_miss_then_hit();
      t_fill_and_tree_default();
      t_order_l0_l2_l3_l1();
      t_other_pair_kept();
      t_write_hit();
      t_write_miss();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule